// File: doc/BRIEF.md
# Pipelined ADC Digital Correction Logic

This block is the digital back end of a three-stage pipelined analog-to-digital converter. On every clock each stage hands over a raw 4-bit flash code. The first stage's code is a coarse estimate. The second and third stages each use one bit more than their share of the resolution, and that extra bit lets later stages absorb decision errors made by the stage before. The codes that belong to one sample arrive one clock apart: stage 1 converts a new sample while stages 2 and 3 are still working on the two samples before it.

The block delays the earlier codes so that all three codes of a sample line up. It then adds them with overlapping binary weights, takes away a fixed centring offset, and clamps the result into the 10-bit output range. After the pipeline has filled, the block produces one corrected word on every clock. A flag marks when the output words are valid.

Top module: `pipe_adc_fix`

## Requirements
- R1: Stage k's code is carried in raw_codes bits [4k+3:4k], with k = 0 for the first stage. Once the codes are aligned, the output equals 64·c1 + 8·c2 + c3 − 36, provided that value lies in 0..1023. Here c1, c2 and c3 are the codes of stages 1, 2 and 3.
- R2: The codes of one sample enter on successive clocks: stage 1 in cycle n, stage 2 in cycle n+1, stage 3 in cycle n+2. The corrected word for that sample is on word_out right after the clock edge that ends cycle n+2.
- R3: Suppose the stage-1 code of a sample of true value V is one too high or one too low, and the later stage codes were derived from the residue this produced. The output is still exactly V.
- R4: Likewise, if the stage-2 code is off by one and the stage-3 code was derived from the resulting residue, the output is exactly V.
- R5: When the weighted sum minus 36 is negative, word_out is 0x000.
- R6: When the weighted sum minus 36 is above 1023, word_out is 0x3FF. A sum of exactly 1023 passes through unchanged.
- R7: word_valid is low during reset and for the first two clock edges after reset is released. It rises at the third edge and then stays high until the next reset.
- R8: Reset is synchronous and active high. It clears word_out, word_valid and every alignment register. The first word after reset therefore sees zero codes from the stages whose registers were cleared, and none of the codes present before the reset.
- R9: A fresh corrected word appears on every clock. Samples presented back to back come out back to back, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_codes | input | 12 | Raw flash codes, 4 bits per stage, stage 1 in the lowest nibble |
| word_out | output | 10 | Corrected, clamped output word |
| word_valid | output | 1 | High once the pipeline has filled after reset |

## Verification
The bound checker watches properties that must hold on every cycle:
- the valid flag rises exactly three edges after reset and then never drops;
- reset clears both the word and the flag;
- every time the checker's own history shows all-zero aligned codes, the output is 0x000;
- every time that history shows all-maximum aligned codes, the output is 0x3FF.

The arithmetic of correction only shows up in the bench's scenarios. There, a reference split of known values into stage codes, including codes deliberately pushed one step off in stage 1 or stage 2, must come back as the original value on the exact cycle set by the skew. Directed raw triples probe both edges of the clamp, and a reset applied with stale codes in the delay lines shows that the registers are really cleared.

// File: rtl/adcfix_pkg.sv
package adcfix_pkg;

    // Left shift applied to the code of stage k (k = 0 is the coarsest stage)
    function automatic int stage_shift(input int stages, input int code_w, input int k);
        return (stages - 1 - k) * (code_w - 1);
    endfunction

    // Width of the corrected word
    function automatic int out_width(input int stages, input int code_w);
        return (stages - 1) * (code_w - 1) + code_w;
    endfunction

    // Centring offset: each redundant stage is shifted by half its nominal span
    function automatic int mid_offset(input int stages, input int code_w);
        int acc;
        acc = 0;
        for (int k = 1; k < stages; k++) begin
            acc += (1 << (code_w - 2)) << stage_shift(stages, code_w, k);
        end
        return acc;
    endfunction

endpackage

// File: rtl/code_delay.sv
module code_delay #(
    parameter int W     = 4,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] line;
    } delay_t;

    delay_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.line[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.line[i] = st_q.line[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.line[DEPTH-1];

endmodule

// File: rtl/overlap_adder.sv
module overlap_adder #(
    parameter int STAGES = 3,
    parameter int CODE_W = 4,
    parameter int OUT_W  = 10
) (
    input  logic [STAGES-1:0][CODE_W-1:0] aligned,
    output logic [OUT_W-1:0]              word
);
    import adcfix_pkg::*;

    localparam int SUM_W = OUT_W + 2;
    localparam logic signed [SUM_W-1:0] OFS   = SUM_W'(mid_offset(STAGES, CODE_W));
    localparam logic signed [SUM_W-1:0] TOP_V = SUM_W'((1 << OUT_W) - 1);

    logic signed [SUM_W-1:0] acc;

    always_comb begin
        acc = -OFS;
        for (int k = 0; k < STAGES; k++) begin
            acc = acc + (SUM_W'(aligned[k]) << stage_shift(STAGES, CODE_W, k));
        end
        if (acc[SUM_W-1]) begin
            word = '0;
        end else if (acc > TOP_V) begin
            word = '1;
        end else begin
            word = acc[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/fill_tracker.sv
module fill_tracker #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    output logic filled
);

    localparam int CNT_W = (STAGES > 2) ? $clog2(STAGES) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             valid;
    } fill_t;

    fill_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.valid) begin
            st_d.cnt   = st_q.cnt + 1'b1;
            st_d.valid = (st_q.cnt == CNT_W'(STAGES - 1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filled = st_q.valid;

endmodule

// File: rtl/pipe_adc_fix.sv
module pipe_adc_fix #(
    parameter int STAGES = 3,
    parameter int CODE_W = 4
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic [STAGES*CODE_W-1:0]                   raw_codes,
    output logic [(STAGES-1)*(CODE_W-1)+CODE_W-1:0]    word_out,
    output logic                                       word_valid
);
    import adcfix_pkg::*;

    localparam int OUT_W = out_width(STAGES, CODE_W);

    typedef struct packed {
        logic [OUT_W-1:0] word;
    } out_t;

    logic [STAGES-1:0][CODE_W-1:0] aligned;
    logic [OUT_W-1:0]              corrected;
    out_t                          out_d, out_q;

    // Stage k waits STAGES-1-k clocks so all codes of one sample meet
    for (genvar k = 0; k < STAGES; k++) begin : g_align
        if (k == STAGES - 1) begin : g_direct
            assign aligned[k] = raw_codes[k*CODE_W +: CODE_W];
        end else begin : g_delayed
            code_delay #(
                .W     (CODE_W),
                .DEPTH (STAGES - 1 - k)
            ) delay_i (
                .clk  (clk),
                .rst  (rst),
                .din  (raw_codes[k*CODE_W +: CODE_W]),
                .dout (aligned[k])
            );
        end
    end

    overlap_adder #(
        .STAGES (STAGES),
        .CODE_W (CODE_W),
        .OUT_W  (OUT_W)
    ) adder_i (
        .aligned (aligned),
        .word    (corrected)
    );

    fill_tracker #(
        .STAGES (STAGES)
    ) fill_i (
        .clk    (clk),
        .rst    (rst),
        .filled (word_valid)
    );

    always_comb begin
        out_d      = out_q;
        out_d.word = corrected;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign word_out = out_q.word;

endmodule

// File: rtl/pipe_adc_fix_chk.sv
module pipe_adc_fix_chk #(
    parameter int STAGES = 3,
    parameter int CODE_W = 4
) (
    input logic                                    clk,
    input logic                                    rst,
    input logic [STAGES*CODE_W-1:0]                raw_codes,
    input logic [(STAGES-1)*(CODE_W-1)+CODE_W-1:0] word_out,
    input logic                                    word_valid
);

    localparam int SEEN_W = $clog2(STAGES + 1);

    logic [STAGES-1:0][STAGES*CODE_W-1:0] hist_q;
    logic [SEEN_W-1:0]                    seen_q;
    logic                                 all_max, all_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            seen_q <= '0;
        end else begin
            hist_q[0] <= raw_codes;
            for (int i = 1; i < STAGES; i++) begin
                hist_q[i] <= hist_q[i-1];
            end
            if (seen_q != SEEN_W'(STAGES)) begin
                seen_q <= seen_q + 1'b1;
            end
        end
    end

    // Codes that fed the word now on word_out: stage k seen STAGES-k clocks ago
    always_comb begin
        all_max  = 1'b1;
        all_zero = 1'b1;
        for (int k = 0; k < STAGES; k++) begin
            if (hist_q[STAGES-1-k][k*CODE_W +: CODE_W] != '1) all_max = 1'b0;
            if (hist_q[STAGES-1-k][k*CODE_W +: CODE_W] != '0) all_zero = 1'b0;
        end
    end

    // R7
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> word_valid);

    // R7
    fill_timing_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (word_valid == (seen_q == SEEN_W'(STAGES))));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (word_out == '0 && !word_valid));

    // R6
    clamp_high_chk: assert property (@(posedge clk) disable iff (rst)
        (word_valid && all_max) |-> (word_out == '1));

    // R5
    clamp_low_chk: assert property (@(posedge clk) disable iff (rst)
        (word_valid && all_zero) |-> (word_out == '0));

endmodule

bind pipe_adc_fix pipe_adc_fix_chk #(
    .STAGES (STAGES),
    .CODE_W (CODE_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .raw_codes  (raw_codes),
    .word_out   (word_out),
    .word_valid (word_valid)
);

// File: tb/pipe_adc_fix_tb_top.sv
`timescale 1ns/1ps
module pipe_adc_fix_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] raw_codes = '0;
    logic [9:0]  word_out;
    logic        word_valid;

    int checks = 0;
    int errors = 0;

    int    s1a[32], s2a[32], s3a[32], expa[32];
    string reqa[32];

    // true value, stage-1 error, stage-2 error
    localparam int VEC_N = 13;
    localparam int VEC [VEC_N][3] = '{
        '{0, 0, 0}, '{1023, 0, 0}, '{512, 0, 0}, '{5, 0, 0}, '{64, 0, 0},
        '{100, 1, 0}, '{70, -1, 0}, '{990, -1, 0}, '{33, 1, 0},
        '{300, 0, 1}, '{298, 0, -1}, '{690, 1, -1}, '{455, -1, 1}
    };

    always #2.5 clk = ~clk;

    pipe_adc_fix dut_i (
        .clk        (clk),
        .rst        (rst),
        .raw_codes  (raw_codes),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Reference split of a known value into stage codes with injected errors
    task automatic split(input int v, input int e1, input int e2,
                         output int c1, output int c2, output int c3);
        int r1, r2;
        c1 = (v >> 6) + e1;
        r1 = v - c1 * 64;
        c2 = ((r1 + 32) >> 3) + e2;
        r2 = r1 - (c2 - 4) * 8;
        c3 = r2 + 4;
    endtask

    task automatic drive(input int c1, input int c2, input int c3);
        raw_codes = {4'(c3), 4'(c2), 4'(c1)};
    endtask

    // Feed n samples with stage skew; word of sample t-3 is checked at iteration t
    task automatic run_stream(input int n);
        for (int t = 0; t < n + 3; t++) begin
            @(negedge clk);
            if (t >= 3) begin
                check(reqa[t-3], int'(word_out), expa[t-3]);
                check("R7", int'(word_valid), 1);
            end
            drive((t < n) ? s1a[t] : 0,
                  (t >= 1 && t - 1 < n) ? s2a[t-1] : 0,
                  (t >= 2 && t - 2 < n) ? s3a[t-2] : 0);
        end
    endtask

    task automatic set_raw(input int i, input int c1, input int c2, input int c3,
                           input int exp_v, input string req);
        s1a[i] = c1; s2a[i] = c2; s3a[i] = c3; expa[i] = exp_v; reqa[i] = req;
    endtask

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Reset with stale maximum codes at the inputs
        rst = 1'b1;
        drive(15, 15, 15);
        repeat (3) @(negedge clk);
        check("R8", int'(word_out), 0);
        check("R8", int'(word_valid), 0);

        // Release; only stage 3 presents a code in cycle 0
        rst = 1'b0;
        drive(0, 0, 15);
        @(negedge clk);
        check("R8", int'(word_out), 0);
        check("R7", int'(word_valid), 0);
        drive(0, 0, 0);
        @(negedge clk);
        check("R7", int'(word_valid), 0);
        @(negedge clk);
        check("R7", int'(word_valid), 1);

        // Table of known values, some with stage errors
        for (int i = 0; i < VEC_N; i++) begin
            int c1, c2, c3;
            split(VEC[i][0], VEC[i][1], VEC[i][2], c1, c2, c3);
            set_raw(i, c1, c2, c3, VEC[i][0],
                    (VEC[i][1] != 0) ? "R3" : (VEC[i][2] != 0) ? "R4" : "R1 R2 R9");
        end
        run_stream(VEC_N);

        // Directed raw codes around both clamp edges
        set_raw(0, 0, 0, 0, 0, "R5");
        set_raw(1, 0, 4, 3, 0, "R5");
        set_raw(2, 0, 4, 4, 0, "R1");
        set_raw(3, 0, 4, 5, 1, "R1");
        set_raw(4, 15, 11, 11, 1023, "R6");
        set_raw(5, 15, 12, 4, 1023, "R6");
        set_raw(6, 15, 15, 15, 1023, "R6");
        set_raw(7, 0, 1, 3, 0, "R5");
        set_raw(8, 8, 4, 4, 512, "R9");
        run_stream(9);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule